// File: doc/BRIEF.md
# CAN Frame Timestamp Capture Unit

This block keeps a free-running 16-bit time base that advances on a bit-time tick, and it takes a timestamp for every CAN frame. The protocol engine pulses a strobe when the identifier field of a frame begins, and the block latches the time base at that moment. The latched value is held and delivered later, through a write strobe into the message-buffer storage. For a received frame the write happens when the engine stores the frame into a buffer. For a transmitted frame it happens only when the engine reports a successful transmission. A failed transmission drops the held value.

When network time synchronisation is enabled, a frame received into buffer 0 clears the time base. The clear lands one cycle after the timestamp write, so the stored stamp still carries the value from before the clear. The protocol engine and the buffer memory lie outside this block. They appear here only as strobes and a write port.

Top module: `can_ts_unit`

## Requirements
- R1: When no synchronisation clear is pending, `timer_now` increases by one on the clock edge where `bit_tick` is 1 and holds its value when `bit_tick` is 0.
- R2: The time base wraps from 0xFFFF to 0x0000 on a tick.
- R3: A pulse on `id_start` latches the value `timer_now` shows in that same cycle, before that cycle's tick takes effect. This held sample is the value a later commit delivers on `ts_value`.
- R4: A pulse on `rx_store` while a sample is held raises `rx_ts_we` for one cycle in the next cycle. In that cycle `rx_ts_idx` equals the `rx_index` that came with the store, and `ts_value` equals the held sample. The held sample is then consumed.
- R5: A pulse on `tx_ok` while a sample is held, with no `rx_store` in the same cycle, raises `tx_ts_we` for one cycle in the next cycle, with `ts_value` equal to the held sample. The sample is then consumed.
- R6: A pulse on `tx_fail` discards the held sample, so a following `tx_ok` or `rx_store` with no new `id_start` writes nothing.
- R7: A second `id_start` before a commit replaces the held sample with the newer value.
- R8: With `sync_en` at 1, an `rx_store` with `rx_index` equal to 0 makes `timer_now` read 0 two cycles after the store cycle. This is one cycle after the `rx_ts_we` cycle, and the stamp written holds the value from before the clear.
- R9: An `rx_store` with `sync_en` at 0, or with a nonzero `rx_index`, leaves the time base running.
- R10: A commit strobe with no held sample writes nothing. If `rx_store` and `tx_ok` arrive together, only the receive write happens and the sample is consumed.
- R11: During reset (`rst_n` low), `timer_now`, `ts_value`, `rx_ts_idx`, `rx_ts_we` and `tx_ts_we` are all 0, and no sample is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse that advances the time base |
| id_start | input | 1 | Start of the identifier field on the bus |
| rx_store | input | 1 | A received frame is being stored into a buffer |
| rx_index | input | IDX_W (4) | Buffer index for the received frame |
| tx_ok | input | 1 | Transmission finished successfully |
| tx_fail | input | 1 | Transmission lost arbitration or ended in error |
| sync_en | input | 1 | Enables the time base clear on a buffer-0 reception |
| timer_now | output | TS_W (16) | Current time base value |
| ts_value | output | TS_W (16) | Timestamp presented with the write strobes |
| rx_ts_idx | output | IDX_W (4) | Buffer index for the receive timestamp write |
| rx_ts_we | output | 1 | Write strobe for the receive-buffer timestamp entry |
| tx_ts_we | output | 1 | Write strobe for the transmit-buffer timestamp entry |

## Verification
The capture path is driven with several patterns. A plain identifier-then-store sequence checks that the stamp is latched at the start strobe and not at the commit. A transmit sequence with success and one with failure separates commit from discard. Two identifier starts before one store show whether the newer sample wins. Buffer-0 stores are made with synchronisation on, with it off, and to a nonzero index, which separates a correct clear, and its one-cycle delay, from a missing or spurious one. A long run of continuous ticks carries the time base across 0xFFFF to show the wrap.

// File: rtl/can_ts_pkg.sv
// Package: shared defaults and the commit decision type for the
// frame timestamp unit. Assumes nothing beyond the standard types.
package can_ts_pkg;
    localparam int TS_W_DEF   = 16;
    localparam int NUM_BUF_DEF = 16;

    // Outcome of a commit decision in one cycle.
    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_RX   = 2'd1,
        CM_TX   = 2'd2
    } commit_e;
endpackage

// File: rtl/can_ts_timer.sv
// Module: free-running time base. Counts bit-time ticks and wraps at
// its width. A clear request wins over a tick in the same cycle.
// Assumes the clear input is a registered one-cycle pulse.
module can_ts_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    // Advance, clear or hold the time base.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (tick)   count <= count + ONE;
    end
endmodule

// File: rtl/can_ts_capture.sv
// Module: sample holder and commit stage. It latches the time base at
// identifier start, and on a receive store or a transmit success it
// issues one registered write with the held sample. A transmit failure
// drops the sample. It also raises the synchronisation clear request
// for a buffer-0 reception. Assumes the strobes are one-cycle pulses.
module can_ts_capture
    import can_ts_pkg::*;
#(
    parameter int W        = 16,
    parameter int IDX_W    = 4,
    parameter int SYNC_BUF = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cur_time,
    input  logic             id_start,
    input  logic             rx_store,
    input  logic [IDX_W-1:0] rx_index,
    input  logic             tx_ok,
    input  logic             tx_fail,
    input  logic             sync_en,
    output logic [W-1:0]     ts_value,
    output logic [IDX_W-1:0] rx_idx,
    output logic             rx_we,
    output logic             tx_we,
    output logic             sync_clear
);
    localparam logic [IDX_W-1:0] SYNC_IDX = IDX_W'(SYNC_BUF);

    logic [W-1:0] sample_q;
    logic         held_q;
    commit_e      decision;

    // Choose which commit, if any, happens this cycle; receive wins.
    always_comb begin
        decision = CM_NONE;
        if (held_q) begin
            if (rx_store)   decision = CM_RX;
            else if (tx_ok) decision = CM_TX;
        end
    end

    // Hold the sample: load at identifier start, drop on use or failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            held_q   <= 1'b0;
        end else begin
            if (decision != CM_NONE || tx_fail) held_q <= 1'b0;
            if (id_start) begin
                sample_q <= cur_time;
                held_q   <= 1'b1;
            end
        end
    end

    // Register the write strobes and the value and index they carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_value <= '0;
            rx_idx   <= '0;
            rx_we    <= 1'b0;
            tx_we    <= 1'b0;
        end else begin
            rx_we <= (decision == CM_RX);
            tx_we <= (decision == CM_TX);
            if (decision != CM_NONE) ts_value <= sample_q;
            if (decision == CM_RX)   rx_idx   <= rx_index;
        end
    end

    // Request the time base clear one cycle after a buffer-0 store.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_clear <= 1'b0;
        else        sync_clear <= rx_store && sync_en && (rx_index == SYNC_IDX);
    end
endmodule

// File: rtl/can_ts_unit.sv
// Module: top of the frame timestamp unit. It joins the time base to
// the capture and commit stage. Assumes a single clock domain, with all
// strobes coming from the protocol engine as one-cycle pulses.
module can_ts_unit #(
    parameter int TS_W    = can_ts_pkg::TS_W_DEF,
    parameter int NUM_BUF = can_ts_pkg::NUM_BUF_DEF,
    parameter int IDX_W   = $clog2(NUM_BUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             id_start,
    input  logic             rx_store,
    input  logic [IDX_W-1:0] rx_index,
    input  logic             tx_ok,
    input  logic             tx_fail,
    input  logic             sync_en,
    output logic [TS_W-1:0]  timer_now,
    output logic [TS_W-1:0]  ts_value,
    output logic [IDX_W-1:0] rx_ts_idx,
    output logic             rx_ts_we,
    output logic             tx_ts_we
);
    logic sync_clear;

    can_ts_timer #(.W(TS_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .clear (sync_clear),
        .count (timer_now)
    );

    can_ts_capture #(.W(TS_W), .IDX_W(IDX_W), .SYNC_BUF(0)) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_time   (timer_now),
        .id_start   (id_start),
        .rx_store   (rx_store),
        .rx_index   (rx_index),
        .tx_ok      (tx_ok),
        .tx_fail    (tx_fail),
        .sync_en    (sync_en),
        .ts_value   (ts_value),
        .rx_idx     (rx_ts_idx),
        .rx_we      (rx_ts_we),
        .tx_we      (tx_ts_we),
        .sync_clear (sync_clear)
    );
endmodule

// File: rtl/can_ts_checker.sv
// Module: property checker for the frame timestamp unit, attached to
// the top by bind. It observes the ports and the internal clear request.
module can_ts_checker #(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             rx_store,
    input logic [IDX_W-1:0] rx_index,
    input logic             tx_ok,
    input logic             sync_en,
    input logic [W-1:0]     timer_now,
    input logic [IDX_W-1:0] rx_ts_idx,
    input logic             rx_ts_we,
    input logic             tx_ts_we,
    input logic             sync_clear
);
    // R1: a tick advances the time base by one, modulo its width (R2)
    a_r1_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_clear && bit_tick) |=> timer_now == W'($past(timer_now) + 1'b1));

    // R1: with no tick, the time base holds
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_clear && !bit_tick) |=> $stable(timer_now));

    // R8: a buffer-0 store with sync on reads 0 two cycles later
    a_r8_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_store && sync_en && rx_index == '0) |=> ##1 timer_now == '0);

    // R4: receive writes only follow a store, and carry its index
    a_r4_rx_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ts_we |-> ($past(rx_store) && rx_ts_idx == $past(rx_index)));

    // R10: at most one write strobe at a time
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ts_we, tx_ts_we}));

    // R5: a transmit write only follows a transmit success
    a_r5_tx_follows_ok: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ts_we |-> $past(tx_ok));
endmodule

bind can_ts_unit can_ts_checker #(.W(TS_W), .IDX_W(IDX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .rx_store   (rx_store),
    .rx_index   (rx_index),
    .tx_ok      (tx_ok),
    .sync_en    (sync_en),
    .timer_now  (timer_now),
    .rx_ts_idx  (rx_ts_idx),
    .rx_ts_we   (rx_ts_we),
    .tx_ts_we   (tx_ts_we),
    .sync_clear (sync_clear)
);

// File: tb/test_can_ts_unit.sv
// Bench: behavioural cycle model compared against the unit every cycle.
module test_can_ts_unit;
    localparam int TS_W  = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_tick = 1'b0, id_start = 1'b0, rx_store = 1'b0;
    logic [IDX_W-1:0] rx_index = '0;
    logic             tx_ok = 1'b0, tx_fail = 1'b0, sync_en = 1'b0;
    logic [TS_W-1:0]  timer_now, ts_value;
    logic [IDX_W-1:0] rx_ts_idx;
    logic             rx_ts_we, tx_ts_we;

    can_ts_unit i_can_ts_unit (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .id_start(id_start),
        .rx_store(rx_store), .rx_index(rx_index), .tx_ok(tx_ok),
        .tx_fail(tx_fail), .sync_en(sync_en), .timer_now(timer_now),
        .ts_value(ts_value), .rx_ts_idx(rx_ts_idx), .rx_ts_we(rx_ts_we),
        .tx_ts_we(tx_ts_we)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int    n_cmp = 0, n_bad = 0;
    string phase = "R11";
    int    tick_every = 0;
    int    cyc_n = 0;
    bit    done = 0;

    // Reference model state
    int m_tmr = 0, m_smp = 0, m_ts = 0, m_idx = 0;
    bit m_held = 0, m_rxwe = 0, m_txwe = 0, m_syncp = 0;

    always @(posedge clk) begin
        int  n_tmr;
        bit  c_rx, c_tx;
        if (!rst_n) begin
            m_tmr = 0; m_smp = 0; m_ts = 0; m_idx = 0;
            m_held = 0; m_rxwe = 0; m_txwe = 0; m_syncp = 0;
        end else begin
            c_rx = m_held && rx_store;
            c_tx = m_held && tx_ok && !rx_store;
            n_tmr = m_syncp ? 0 : (bit_tick ? (m_tmr + 1) % 65536 : m_tmr);
            m_rxwe = c_rx;
            m_txwe = c_tx;
            if (c_rx || c_tx) m_ts = m_smp;
            if (c_rx) m_idx = int'(rx_index);
            if (c_rx || c_tx || tx_fail) m_held = 0;
            if (id_start) begin m_smp = m_tmr; m_held = 1; end
            m_syncp = rx_store && sync_en && rx_index == 0;
            m_tmr = n_tmr;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) at cycle %0d: actual %0h expected %0h",
                     tag, phase, cyc_n, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare_all();
        chk("R1 timer", int'(timer_now), m_tmr);
        chk("R4 rx_we", int'(rx_ts_we), int'(m_rxwe));
        chk("R5 tx_we", int'(tx_ts_we), int'(m_txwe));
        if (m_rxwe || m_txwe) chk("R3 ts_value", int'(ts_value), m_ts);
        if (m_rxwe) chk("R4 rx_idx", int'(rx_ts_idx), m_idx);
    endtask

    // One clock: sample at falling edge, then drive next inputs.
    task automatic cyc();
        @(negedge clk);
        cyc_n++;
        compare_all();
        id_start = 0; rx_store = 0; tx_ok = 0; tx_fail = 0;
        bit_tick = (tick_every != 0) && (cyc_n % tick_every == 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic p_id();                 begin id_start = 1; cyc(); end endtask
    task automatic p_rx(int idx);          begin rx_store = 1; rx_index = IDX_W'(idx); cyc(); end endtask
    task automatic p_txok();               begin tx_ok = 1; cyc(); end endtask
    task automatic p_txfail();             begin tx_fail = 1; cyc(); end endtask

    initial begin
        // R11: reset state
        phase = "R11";
        repeat (3) @(negedge clk);
        chk("R11 timer", int'(timer_now), 0);
        chk("R11 ts", int'(ts_value), 0);
        chk("R11 idx", int'(rx_ts_idx), 0);
        chk("R11 we", int'({rx_ts_we, tx_ts_we}), 0);
        rst_n = 1;
        // R1: irregular ticking
        phase = "R1"; tick_every = 3; idle(20);
        tick_every = 1; idle(10);
        // R3 / R4: receive path
        phase = "R4"; tick_every = 2;
        p_id(); idle(5); p_rx(5); idle(3);
        // R5: transmit success
        phase = "R5"; p_id(); idle(4); p_txok(); idle(3);
        // R6: failed transmit discards
        phase = "R6"; p_id(); idle(2); p_txfail(); idle(2); p_txok(); idle(2); p_rx(7); idle(2);
        // R7: newer sample replaces
        phase = "R7"; p_id(); idle(6); p_id(); idle(3); p_rx(9); idle(3);
        // R10: commit with nothing held, and simultaneous commits
        phase = "R10"; p_rx(2); p_txok(); idle(2);
        p_id(); idle(2); rx_store = 1; tx_ok = 1; rx_index = 4'd3; cyc(); idle(2); p_txok(); idle(2);
        // R8: buffer-0 sync clear
        phase = "R8"; sync_en = 1; tick_every = 1;
        idle(15); p_id(); idle(4); p_rx(0); idle(5);
        // R9: no clear with sync off or nonzero index
        phase = "R9"; sync_en = 0; idle(10); p_id(); idle(2); p_rx(0); idle(4);
        sync_en = 1; p_id(); idle(2); p_rx(3); idle(4); sync_en = 0;
        // R2: long run through the wrap
        phase = "R2"; tick_every = 1; idle(65600);
        p_id(); idle(2); p_txok(); idle(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(190000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (phase %s): actual hung expected done", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule